// File: doc/BRIEF.md
# Triple-Redundant Voted Register

This block is a word-wide state register hardened against single-event upsets. It stores three separate copies of its word. Each copy has its own next-state path and its own 2-of-3 majority voter. When the copy is not being loaded with fresh data, it is rewritten on every clock edge from its voter's result. A flipped bit in any one copy is therefore outvoted right away, and it is wiped out at the next edge instead of staying in the register.

Three voted outputs are available, one for each voter, so that the logic downstream can stay triplicated. A disagreement flag is high for as long as the three stored copies are not identical. A test port can flip one chosen bit of one chosen copy as that copy is written. This lets a bench or a fault campaign check the masking and the recovery.

Top module: `tmr_vreg`

## Requirements
- R1: A clock edge with `srst_i` high clears all three copies. After that edge, all three outputs read zero and `mismatch_o` is low.
- R2: A clock edge with `load_i` high and `srst_i` low writes `din_i` into every copy. After that edge, all three outputs equal that `din_i`.
- R3: A clock edge with `load_i` low and `srst_i` low rewrites each copy from its own voter. The voted outputs keep their value.
- R4: Each output bit is the majority of the corresponding bits of the three copies. A single corrupted copy never changes any output.
- R5: A copy that differs from the other two is rewritten from the vote at the next edge, whether `load_i` is high or low. It then agrees with the other two again.
- R6: `mismatch_o` is high exactly while the three copies are not all bit-for-bit identical. After a single upset it stays high for one cycle.
- R7: A clock edge with `upset_i` high and `srst_i` low inverts bit `upset_bit_i` of the copy selected by `upset_lane_i` relative to the value that copy would have stored. The lane codes are 0, 1 and 2 for the three copies. Code 3 selects no copy and has no effect.
- R8: `srst_i` takes priority over `load_i` and over `upset_i`.
- R9: The three voted outputs are equal whenever at most one copy is corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous active-high clear |
| load_i | input | 1 | Write `din_i` into the register |
| din_i | input | WIDTH | Data to store, fanned out to each copy |
| upset_i | input | 1 | Test: corrupt one bit of one copy at this edge |
| upset_lane_i | input | 2 | Test: copy to corrupt (0..2, 3 = none) |
| upset_bit_i | input | BIT_W | Test: bit position to invert |
| dout_a_o | output | WIDTH | Voted value from voter 0 |
| dout_b_o | output | WIDTH | Voted value from voter 1 |
| dout_c_o | output | WIDTH | Voted value from voter 2 |
| mismatch_o | output | 1 | The stored copies disagree |

## Verification
The properties assume a single-fault environment: at most one copy is corrupted at any time. With that assumption, the voted outputs are fault-free, and the disagreement flag has cleared one cycle after any upset. The stimulus stays within this assumption by injecting at most one upset per edge. An upset on one edge may be followed by an upset on the next, because the earlier fault is repaired at that same edge. Reset is held from time zero until the first edge has cleared the copies, so no property sees unknown state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned TMR_COPIES = 3;

    typedef enum logic [1:0] {
        LANE_A    = 2'd0,
        LANE_B    = 2'd1,
        LANE_C    = 2'd2,
        LANE_NONE = 2'd3
    } lane_sel_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cp0_i,
    input  logic [WIDTH-1:0] cp1_i,
    input  logic [WIDTH-1:0] cp2_i,
    output logic [WIDTH-1:0] vote_o
);
    import tmr_pkg::*;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign vote_o[b] = maj3(cp0_i[b], cp1_i[b], cp2_i[b]);
    end

    // R4: whenever two copies agree, the vote follows them
    always_comb begin
        if (!$isunknown({cp0_i, cp1_i, cp2_i}) && (cp0_i == cp1_i || cp0_i == cp2_i))
            assert_pair_wins_R4: assert (vote_o == cp0_i);
    end

endmodule

// File: rtl/tmr_lane.sv
module tmr_lane #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned BIT_W   = 3,
    parameter int unsigned LANE_ID = 0
) (
    input  logic             clk_i,
    input  logic             srst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] vote_i,
    input  logic             upset_i,
    input  logic [1:0]       upset_lane_i,
    input  logic [BIT_W-1:0] upset_bit_i,
    output logic [WIDTH-1:0] copy_o
);
    localparam logic [1:0]       MY_CODE = 2'(LANE_ID);
    localparam logic [WIDTH-1:0] ONE_HOT = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic [WIDTH-1:0] flip_d;

    always_comb begin
        flip_d = '0;
        if (upset_i && upset_lane_i == MY_CODE)
            flip_d = ONE_HOT << upset_bit_i;
        st_d = st_q;
        if (srst_i)
            st_d.word = '0;
        else
            st_d.word = (load_i ? din_i : vote_i) ^ flip_d;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign copy_o = st_q.word;

endmodule

// File: rtl/tmr_vreg.sv
module tmr_vreg #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk_i,
    input  logic             srst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             upset_i,
    input  logic [1:0]       upset_lane_i,
    input  logic [BIT_W-1:0] upset_bit_i,
    output logic [WIDTH-1:0] dout_a_o,
    output logic [WIDTH-1:0] dout_b_o,
    output logic [WIDTH-1:0] dout_c_o,
    output logic             mismatch_o
);
    import tmr_pkg::*;

    logic [WIDTH-1:0] copy_q [TMR_COPIES];
    logic [WIDTH-1:0] vote_d [TMR_COPIES];
    logic             differ_d;

    for (genvar k = 0; k < TMR_COPIES; k++) begin : g_copy
        tmr_voter #(.WIDTH(WIDTH)) voter_i (
            .cp0_i  (copy_q[0]),
            .cp1_i  (copy_q[1]),
            .cp2_i  (copy_q[2]),
            .vote_o (vote_d[k])
        );

        tmr_lane #(.WIDTH(WIDTH), .BIT_W(BIT_W), .LANE_ID(k)) lane_i (
            .clk_i        (clk_i),
            .srst_i       (srst_i),
            .load_i       (load_i),
            .din_i        (din_i),
            .vote_i       (vote_d[k]),
            .upset_i      (upset_i),
            .upset_lane_i (upset_lane_i),
            .upset_bit_i  (upset_bit_i),
            .copy_o       (copy_q[k])
        );
    end

    always_comb begin
        differ_d = (copy_q[0] != copy_q[1]) || (copy_q[1] != copy_q[2]);
    end

    assign dout_a_o   = vote_d[0];
    assign dout_b_o   = vote_d[1];
    assign dout_c_o   = vote_d[2];
    assign mismatch_o = differ_d;

    // R1 and R8: clear wins over load and upset
    assert_reset_clears_R1: assert property (@(posedge clk_i)
        srst_i |=> (dout_a_o == '0 && dout_c_o == '0 && !mismatch_o));

    // R2: load reaches the voted outputs after one edge
    assert_load_R2: assert property (@(posedge clk_i) disable iff (srst_i)
        load_i |=> (dout_b_o == $past(din_i)));

    // R3 and R4: a refresh edge keeps the vote, even if one copy is hit
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (srst_i)
        (!load_i && !mismatch_o) |=> (dout_a_o == $past(dout_a_o)));

    // R5: without a new upset the copies agree after the next edge
    assert_refresh_R5: assert property (@(posedge clk_i) disable iff (srst_i)
        !upset_i |=> !mismatch_o);

    // R6 and R7: an upset on a real lane shows up as disagreement
    assert_flag_R6: assert property (@(posedge clk_i) disable iff (srst_i)
        (upset_i && upset_lane_i != 2'd3) |=> mismatch_o);

    // R9: the three voters agree under a single fault
    assert_outputs_equal_R9: assert property (@(posedge clk_i) disable iff (srst_i)
        (dout_a_o == dout_b_o) && (dout_b_o == dout_c_o));

endmodule

// File: tb/tmr_vreg_tb_top.sv
module tmr_vreg_tb_top;
    import tmr_pkg::*;

    localparam int unsigned W  = 8;
    localparam int unsigned BW = 3;

    logic          clk = 1'b0;
    logic          srst = 1'b1;
    logic          load = 1'b0;
    logic [W-1:0]  din = '0;
    logic          upset = 1'b0;
    logic [1:0]    ulane = 2'd3;
    logic [BW-1:0] ubit = '0;
    logic [W-1:0]  da, db, dc;
    logic          mm;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_val_q [$];
    logic         exp_mm_q  [$];
    string        exp_tag_q [$];
    logic [W-1:0] model = '0;

    always #4 clk = ~clk;

    tmr_vreg #(.WIDTH(W), .BIT_W(BW)) dut_i (
        .clk_i(clk), .srst_i(srst), .load_i(load), .din_i(din),
        .upset_i(upset), .upset_lane_i(ulane), .upset_bit_i(ubit),
        .dout_a_o(da), .dout_b_o(db), .dout_c_o(dc), .mismatch_o(mm)
    );

    // driver: applies one edge worth of inputs and queues the expected outcome
    task automatic step(input logic r, input logic ld, input logic [W-1:0] d,
                        input logic up, input logic [1:0] ln, input logic [BW-1:0] bt,
                        input string tag);
        logic [W-1:0] ev;
        logic         em;
        @(negedge clk);
        srst = r; load = ld; din = d; upset = up; ulane = ln; ubit = bt;
        if (r) begin
            ev = '0; em = 1'b0;
        end else begin
            ev = ld ? d : model;
            em = up && (ln != 2'd3);
        end
        model = ev;
        exp_val_q.push_back(ev);
        exp_mm_q.push_back(em);
        exp_tag_q.push_back(tag);
    endtask

    // monitor: compares after each edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_val_q.size() > 0) begin
                logic [W-1:0] ev;
                logic         em;
                string        tg;
                ev = exp_val_q.pop_front();
                em = exp_mm_q.pop_front();
                tg = exp_tag_q.pop_front();
                n_vec++;
                if (da !== ev || db !== ev || dc !== ev || mm !== em) begin
                    n_fail++;
                    $display("FAIL %s: outputs %h/%h/%h flag %b, expected %h flag %b",
                             tg, da, db, dc, mm, ev, em);
                end
            end
        end
    end

    initial begin
        // R1 / R8: clear, also against load and upset
        step(1, 0, 8'h00, 0, 3, 0, "R1");
        step(1, 1, 8'hFF, 1, 0, 5, "R8");
        step(0, 0, 8'h00, 0, 3, 0, "R3");
        // R2: several load patterns
        step(0, 1, 8'hA5, 0, 3, 0, "R2");
        step(0, 1, 8'h5A, 0, 3, 0, "R2");
        step(0, 1, 8'hFF, 0, 3, 0, "R2");
        step(0, 1, 8'h3C, 0, 3, 0, "R2");
        // R3: hold by refresh
        step(0, 0, 8'hC3, 0, 3, 0, "R3");
        step(0, 0, 8'h00, 0, 3, 0, "R3");
        // R4 / R6 / R7: upset each lane, then R5 recovery
        for (int ln = 0; ln < 3; ln++) begin
            step(0, 0, 8'h11, 1, 2'(ln), 3'(ln * 3), "R7");
            step(0, 0, 8'h22, 0, 3, 0, "R5");
        end
        // R4: boundary bits
        step(0, 0, 8'h00, 1, LANE_C, 3'd7, "R4");
        step(0, 0, 8'h00, 0, 3, 0, "R5");
        step(0, 0, 8'h00, 1, LANE_A, 3'd0, "R4");
        step(0, 0, 8'h00, 0, 3, 0, "R6");
        // R7: lane code 3 has no effect
        step(0, 0, 8'h77, 1, LANE_NONE, 3'd2, "R7");
        // R5: upset during a load, repaired by a refresh or by a load
        step(0, 1, 8'h81, 1, LANE_B, 3'd4, "R5");
        step(0, 0, 8'h00, 0, 3, 0, "R5");
        step(0, 1, 8'h18, 1, LANE_A, 3'd1, "R5");
        step(0, 1, 8'hE7, 0, 3, 0, "R5");
        // R9: back-to-back upsets on different lanes
        step(0, 0, 8'h00, 1, LANE_A, 3'd6, "R9");
        step(0, 0, 8'h00, 1, LANE_B, 3'd6, "R9");
        step(0, 0, 8'h00, 1, LANE_C, 3'd2, "R9");
        step(0, 0, 8'h00, 0, 3, 0, "R9");
        // R8: clear while a copy is corrupted
        step(0, 0, 8'h00, 1, LANE_B, 3'd0, "R8");
        step(1, 1, 8'hAA, 1, LANE_A, 3'd3, "R8");
        step(0, 1, 8'h96, 0, 3, 0, "R2");
        step(0, 0, 8'h00, 0, 3, 0, "R3");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule